// File: doc/BRIEF.md
# I2C Offload Transaction Generator

This block sits in front of a byte-level I2C master engine and carries out a complete single-message transfer of one to eight bytes without further software help. Software stages up to eight transmit bytes in two 32-bit words and then writes a single control word. That word carries the direction, the slave address, the 10-bit addressing flag, the length minus one and a go bit. The generator then drives the byte engine through START, one or two address bytes, the data bytes and STOP.

When the STOP completes, the generator sets a completion cause bit and an error status bit, and raises an interrupt if the mask allows it. Received bytes are collected into two 32-bit receive words in little-endian order. The byte engine is reached through a command/completion handshake. The block issues a command and holds it until the engine pulses done, along with the slave's acknowledge result or the received byte.

Top module: `i2c_xfer_offload`

## Requirements
- R1: After reset, every register reads zero, `eng_cmd_valid` is low and `irq` is low.
- R2: Register offsets are 0xC0 transmit low word, 0xC4 transmit high word, 0xC8 receive low word, 0xCC receive high word, 0xD0 control, 0xD4 status, 0xD8 completion cause and 0xDC interrupt mask. The transmit words, control and mask (bit 0) read back what was written.
- R3: Control fields are: bit 19 go, bit 12 ten-bit address, bits [11:2] slave address, bit 1 read (the transfer reads when set and writes otherwise), bit 0 write, bits [15:13] transmit length minus one and bits [18:16] receive length minus one. Writing go=1 while idle starts a transfer.
- R4: Engine opcodes are START=0, WRITE=1, READ=2 and STOP=3. A transfer issues START, then the address, then data, then STOP. A 7-bit address byte is {addr[6:0], dir}, with dir=1 for a read.
- R5: With ten-bit addressing, two address bytes are sent: {5'b11110, addr[9:8], dir} and then addr[7:0].
- R6: Write data bytes go out little-endian: byte k is bits [8k+7:8k] of the 64-bit value {transmit high, transmit low}, starting at k=0.
- R7: In a read, every READ command carries `eng_cmd_ack`=1 except the last, which carries 0 and is followed by STOP. Received byte k lands in bits [8k+7:8k] of {receive high, receive low}, and both receive words clear to zero when a transfer starts.
- R8: A NACK on an address byte or a write data byte is followed directly by STOP, and status bit 0 reads 1 after completion. A transfer with no NACK leaves status bit 0 at 0.
- R9: Completion sets cause bit 0 the cycle after the STOP done. Writing the cause register with bit 0 = 0 clears it, but a completion in the same cycle wins and leaves it set.
- R10: `irq` is high exactly when cause bit 0 and mask bit 0 are both set.
- R11: Writing control with go=0 during a transfer abandons it. `eng_cmd_valid` drops the next cycle, control reads zero and cause is not set.
- R12: Writing control with go=1 during a transfer is ignored. Control keeps its value and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| eng_cmd_valid | output | 1 | Command to the byte engine is pending |
| eng_cmd_op | output | 3 | Command opcode (START=0, WRITE=1, READ=2, STOP=3) |
| eng_cmd_byte | output | 8 | Byte to transmit for WRITE |
| eng_cmd_ack | output | 1 | For READ: 1 = acknowledge the byte, 0 = NACK it |
| eng_done | input | 1 | One-cycle pulse: the current command has finished |
| eng_nack | input | 1 | With `eng_done` on WRITE: slave did not acknowledge |
| eng_rx_byte | input | 8 | With `eng_done` on READ: received byte |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same clock cycle: the STOP completion that sets the cause bit, and a software write of zero to the cause register. The bench's engine model provokes this by issuing the cause-clear write in the very cycle it returns done for STOP. The bench then judges the outcome by reading the cause bit as 1 and seeing `irq` high afterwards. A second overlap is a control write arriving mid-transfer. It is placed while the engine holds a command, and is judged by the control readback and by the scoreboard seeing the original command stream, or none after an abandon.

// File: rtl/i2c_ofl_pkg.sv
package i2c_ofl_pkg;

  localparam int unsigned BUS_AW = 8;
  localparam int unsigned DW     = 32;
  localparam int unsigned NBYTES = 8;
  localparam int unsigned IDX_W  = $clog2(NBYTES);
  localparam int unsigned SLV_AW = 10;
  localparam int unsigned BUF_W  = NBYTES * 8;
  localparam int unsigned CTRL_W = 20;

  localparam logic [BUS_AW-1:0] OFS_TX_LO = 8'hC0;
  localparam logic [BUS_AW-1:0] OFS_TX_HI = 8'hC4;
  localparam logic [BUS_AW-1:0] OFS_RX_LO = 8'hC8;
  localparam logic [BUS_AW-1:0] OFS_RX_HI = 8'hCC;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'hD0;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 8'hD4;
  localparam logic [BUS_AW-1:0] OFS_CAUSE = 8'hD8;
  localparam logic [BUS_AW-1:0] OFS_MASK  = 8'hDC;

  localparam int unsigned CB_RD  = 1;
  localparam int unsigned CB_ADR = 2;
  localparam int unsigned CB_TEN = 12;
  localparam int unsigned CB_TXN = 13;
  localparam int unsigned CB_RXN = 16;
  localparam int unsigned CB_GO  = 19;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_STOP  = 3'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_ADR1, SQ_ADR2, SQ_WDAT, SQ_RDAT, SQ_STOP
  } seq_st_e;

  typedef struct packed {
    logic              rd;
    logic              ten;
    logic [SLV_AW-1:0] addr;
    logic [IDX_W-1:0]  txn;
    logic [IDX_W-1:0]  rxn;
  } xfer_cfg_t;

endpackage

// File: rtl/ofl_regs.sv
module ofl_regs
  import i2c_ofl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BUS_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic              fin_err,
  input  logic [BUF_W-1:0]  rx_data,
  output logic              start,
  output logic              abort,
  output xfer_cfg_t         cfg,
  output logic [BUF_W-1:0]  tx_data,
  output logic              irq
);

  logic [DW-1:0]     tx_lo_q, tx_hi_q, tx_lo_d, tx_hi_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              mask_q, mask_d, cause_q, cause_d, err_q, err_d;
  logic              sel_ctrl, ctrl_we;

  assign sel_ctrl = (addr == OFS_CTRL);
  assign ctrl_we  = we && sel_ctrl;

  always_comb begin
    start   = ctrl_we && !busy && wdata[CB_GO];
    abort   = ctrl_we && busy && !wdata[CB_GO];
    tx_lo_d = tx_lo_q;
    tx_hi_d = tx_hi_q;
    mask_d  = mask_q;
    ctrl_d  = ctrl_q;
    cause_d = cause_q;
    err_d   = err_q;
    if (we && addr == OFS_TX_LO) tx_lo_d = wdata;
    if (we && addr == OFS_TX_HI) tx_hi_d = wdata;
    if (we && addr == OFS_MASK)  mask_d  = wdata[0];
    if (ctrl_we && !busy)        ctrl_d  = wdata[CTRL_W-1:0];
    else if (abort)              ctrl_d  = '0;
    if (fin)                                         cause_d = 1'b1;
    else if (we && addr == OFS_CAUSE && !wdata[0])   cause_d = 1'b0;
    if (start)    err_d = 1'b0;
    else if (fin) err_d = fin_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lo_q <= '0;
      tx_hi_q <= '0;
      ctrl_q  <= '0;
      mask_q  <= 1'b0;
      cause_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      tx_lo_q <= tx_lo_d;
      tx_hi_q <= tx_hi_d;
      ctrl_q  <= ctrl_d;
      mask_q  <= mask_d;
      cause_q <= cause_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_TX_LO: rdata = tx_lo_q;
      OFS_TX_HI: rdata = tx_hi_q;
      OFS_RX_LO: rdata = rx_data[DW-1:0];
      OFS_RX_HI: rdata = rx_data[BUF_W-1:DW];
      OFS_CTRL:  rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      OFS_STAT:  rdata = {{(DW-1){1'b0}}, err_q};
      OFS_CAUSE: rdata = {{(DW-1){1'b0}}, cause_q};
      OFS_MASK:  rdata = {{(DW-1){1'b0}}, mask_q};
      default:   rdata = '0;
    endcase
  end

  assign cfg.rd   = ctrl_q[CB_RD];
  assign cfg.ten  = ctrl_q[CB_TEN];
  assign cfg.addr = ctrl_q[CB_ADR +: SLV_AW];
  assign cfg.txn  = ctrl_q[CB_TXN +: IDX_W];
  assign cfg.rxn  = ctrl_q[CB_RXN +: IDX_W];
  assign tx_data  = {tx_hi_q, tx_lo_q};
  assign irq      = cause_q && mask_q;

  // R9: a completion always leaves the cause bit set, even against a clear
  a_r9_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> cause_q);

  // R12: go while busy leaves the control word untouched
  a_r12_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && busy && wdata[CB_GO]) |=> $stable(ctrl_q));

  // R8: a fresh transfer starts with a clean error bit
  a_r8_err_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !err_q);

endmodule

// File: rtl/ofl_rxbuf.sv
module ofl_rxbuf
  import i2c_ofl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       byte_in,
  output logic [BUF_W-1:0] data
);

  logic [7:0] lane_q [NBYTES];
  logic [7:0] lane_d [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_comb begin
      lane_d[g] = lane_q[g];
      if (clr)                                  lane_d[g] = '0;
      else if (we && idx == IDX_W'(g))          lane_d[g] = byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[g] <= '0;
      else        lane_q[g] <= lane_d[g];
    end

    assign data[g*8 +: 8] = lane_q[g];
  end

  // R7: the receive words are empty at the start of every transfer
  a_r7_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (data == '0));

endmodule

// File: rtl/ofl_seq.sv
module ofl_seq
  import i2c_ofl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  xfer_cfg_t        cfg,
  input  logic [BUF_W-1:0] tx_data,
  input  logic             eng_done,
  input  logic             eng_nack,
  output logic             cmd_valid,
  output eng_op_e          cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_ack,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic             fin,
  output logic             fin_err,
  output logic             busy
);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d;
  seq_st_e          after_adr;

  assign after_adr = cfg.rd ? SQ_RDAT : SQ_WDAT;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    err_d = err_q;
    fin   = 1'b0;
    rx_we = 1'b0;
    if (abort) begin
      st_d = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start) begin
          st_d  = SQ_START;
          idx_d = '0;
          err_d = 1'b0;
        end
        SQ_START: if (eng_done) st_d = SQ_ADR1;
        SQ_ADR1: if (eng_done) begin
          if (eng_nack) begin
            st_d  = SQ_STOP;
            err_d = 1'b1;
          end else begin
            st_d = cfg.ten ? SQ_ADR2 : after_adr;
          end
        end
        SQ_ADR2: if (eng_done) begin
          if (eng_nack) begin
            st_d  = SQ_STOP;
            err_d = 1'b1;
          end else begin
            st_d = after_adr;
          end
        end
        SQ_WDAT: if (eng_done) begin
          if (eng_nack) begin
            st_d  = SQ_STOP;
            err_d = 1'b1;
          end else if (idx_q == cfg.txn) begin
            st_d = SQ_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        SQ_RDAT: if (eng_done) begin
          rx_we = 1'b1;
          if (idx_q == cfg.rxn) st_d = SQ_STOP;
          else                  idx_d = idx_q + 1'b1;
        end
        SQ_STOP: if (eng_done) begin
          fin  = 1'b1;
          st_d = SQ_IDLE;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    cmd_byte = '0;
    unique case (st_q)
      SQ_START: cmd_op = OP_START;
      SQ_ADR1: begin
        cmd_op   = OP_WRITE;
        cmd_byte = cfg.ten ? {5'b11110, cfg.addr[9:8], cfg.rd}
                           : {cfg.addr[6:0], cfg.rd};
      end
      SQ_ADR2: begin
        cmd_op   = OP_WRITE;
        cmd_byte = cfg.addr[7:0];
      end
      SQ_WDAT: begin
        cmd_op   = OP_WRITE;
        cmd_byte = tx_data[{idx_q, 3'b000} +: 8];
      end
      SQ_RDAT: cmd_op = OP_READ;
      default: cmd_op = OP_STOP;
    endcase
  end

  assign busy      = (st_q != SQ_IDLE);
  assign cmd_valid = busy;
  assign cmd_ack   = (idx_q != cfg.rxn);
  assign rx_idx    = idx_q;
  assign fin_err   = err_q;

  // R4: a started transfer opens with START
  a_r4_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (cmd_valid && cmd_op == OP_START));

  // R7: the NACKed final read byte is followed by STOP
  a_r7_last_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_READ && !cmd_ack && eng_done && !abort)
      |=> (cmd_valid && cmd_op == OP_STOP));

  // R8: a slave NACK on any written byte leads straight to STOP
  a_r8_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRITE && eng_done && eng_nack && !abort)
      |=> (cmd_valid && cmd_op == OP_STOP));

  // R11: an abandon silences the engine command the next cycle
  a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !cmd_valid);

endmodule

// File: rtl/i2c_xfer_offload.sv
module i2c_xfer_offload
  import i2c_ofl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              eng_cmd_valid,
  output logic [2:0]        eng_cmd_op,
  output logic [7:0]        eng_cmd_byte,
  output logic              eng_cmd_ack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rx_byte,
  output logic              irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             start, abort, busy, fin, fin_err, rx_we;
  logic [IDX_W-1:0] rx_idx;
  logic [BUF_W-1:0] tx_data, rx_data;
  xfer_cfg_t        cfg;
  eng_op_e          op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ofl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .busy    (busy),
    .fin     (fin),
    .fin_err (fin_err),
    .rx_data (rx_data),
    .start   (start),
    .abort   (abort),
    .cfg     (cfg),
    .tx_data (tx_data),
    .irq     (irq)
  );

  ofl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .abort     (abort),
    .cfg       (cfg),
    .tx_data   (tx_data),
    .eng_done  (eng_done),
    .eng_nack  (eng_nack),
    .cmd_valid (eng_cmd_valid),
    .cmd_op    (op),
    .cmd_byte  (eng_cmd_byte),
    .cmd_ack   (eng_cmd_ack),
    .rx_we     (rx_we),
    .rx_idx    (rx_idx),
    .fin       (fin),
    .fin_err   (fin_err),
    .busy      (busy)
  );

  ofl_rxbuf u_rxbuf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (start),
    .we      (rx_we),
    .idx     (rx_idx),
    .byte_in (eng_rx_byte),
    .data    (rx_data)
  );

  assign eng_cmd_op = op;

endmodule

// File: tb/i2c_xfer_offload_tb_top.sv
module i2c_xfer_offload_tb_top;

  localparam logic [2:0] O_START = 3'd0, O_WRITE = 3'd1, O_READ = 3'd2, O_STOP = 3'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        t_we, c_we;
  logic [7:0]  t_addr;
  logic [31:0] t_wdata;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        eng_cmd_valid, eng_cmd_ack, eng_done, eng_nack, irq;
  logic [2:0]  eng_cmd_op;
  logic [7:0]  eng_cmd_byte, eng_rx_byte;

  typedef struct {
    logic [2:0] op;
    logic [7:0] bv;
    logic       ack;
    logic       nk;
    logic [7:0] rx;
    logic       clr;
    string      tag;
  } exp_t;

  exp_t expq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   lat = 2;

  always #4 clk = ~clk;

  assign bus_we    = t_we | c_we;
  assign bus_addr  = c_we ? 8'hD8 : t_addr;
  assign bus_wdata = c_we ? 32'h0 : t_wdata;

  i2c_xfer_offload dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_op(eng_cmd_op),
    .eng_cmd_byte(eng_cmd_byte), .eng_cmd_ack(eng_cmd_ack),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rx_byte(eng_rx_byte),
    .irq(irq)
  );

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] op, input logic [7:0] bv, input logic ack,
                      input logic nk, input logic [7:0] rx, input logic clr, input string tag);
    exp_t e;
    e.op = op; e.bv = bv; e.ack = ack; e.nk = nk; e.rx = rx; e.clr = clr; e.tag = tag;
    expq.push_back(e);
  endtask

  // Monitor and engine model: pops the expected command and answers it
  initial begin
    exp_t e;
    eng_done = 1'b0; eng_nack = 1'b0; eng_rx_byte = 8'h00; c_we = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && eng_cmd_valid) begin
        if (expq.size() == 0) begin
          chk_eq("R4 unexpected command", {61'h0, eng_cmd_op}, 64'h7);
          e.op = O_STOP; e.nk = 1'b0; e.rx = 8'h00; e.clr = 1'b0;
        end else begin
          e = expq.pop_front();
          chk_eq({e.tag, " op"}, {61'h0, eng_cmd_op}, {61'h0, e.op});
          if (e.op == O_WRITE) chk_eq({e.tag, " byte"}, {56'h0, eng_cmd_byte}, {56'h0, e.bv});
          if (e.op == O_READ)  chk_eq({e.tag, " ack"}, {63'h0, eng_cmd_ack}, {63'h0, e.ack});
        end
        repeat (lat) @(posedge clk);
        #1;
        eng_done = 1'b1; eng_nack = e.nk; eng_rx_byte = e.rx; c_we = e.clr;
        @(posedge clk);
        #1;
        eng_done = 1'b0; eng_nack = 1'b0; c_we = 1'b0;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    t_addr = a; t_wdata = d; t_we = 1'b1;
    @(negedge clk);
    t_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    t_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cause();
    logic [31:0] d;
    int k = 0;
    do begin
      rd(8'hD8, d);
      k++;
    end while (d[0] == 1'b0 && k < 3000);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] ctrlw(input bit r, input bit ten, input logic [9:0] a, input int n);
    logic [31:0] w = 32'h0;
    w[19] = 1'b1; w[1] = r; w[0] = !r; w[11:2] = a; w[12] = ten;
    if (r) w[18:16] = 3'(n - 1);
    else   w[15:13] = 3'(n - 1);
    return w;
  endfunction

  // Driver: push the expected command stream, then launch the transfer
  task automatic xfer(input bit r, input bit ten, input logic [9:0] a, input int n,
                      input logic [63:0] dat, input int nack_at, input bit clr_stop,
                      input string tag);
    bit stopped = 0;
    push(O_START, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, {tag, " START"});
    if (ten) begin
      push(O_WRITE, {5'b11110, a[9:8], r}, 1'b0, nack_at == 0, 8'h00, 1'b0, {tag, " adr1"});
      if (nack_at == 0) stopped = 1;
      else push(O_WRITE, a[7:0], 1'b0, 1'b0, 8'h00, 1'b0, {tag, " adr2"});
    end else begin
      push(O_WRITE, {a[6:0], r}, 1'b0, nack_at == 0, 8'h00, 1'b0, {tag, " adr"});
      if (nack_at == 0) stopped = 1;
    end
    for (int i = 0; i < n && !stopped; i++) begin
      if (r) push(O_READ, 8'h00, i != n - 1, 1'b0, dat[i*8 +: 8], 1'b0, {tag, " rdata"});
      else begin
        push(O_WRITE, dat[i*8 +: 8], 1'b0, nack_at == i + 1, 8'h00, 1'b0, {tag, " wdata"});
        if (nack_at == i + 1) stopped = 1;
      end
    end
    push(O_STOP, 8'h00, 1'b0, 1'b0, 8'h00, clr_stop, {tag, " STOP"});
    if (!r) begin
      wr(8'hC0, dat[31:0]);
      wr(8'hC4, dat[63:32]);
    end
    wr(8'hD0, ctrlw(r, ten, a, n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    t_we = 1'b0; t_addr = 8'h00; t_wdata = 32'h0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 8'hC0; a <= 8'hDC; a += 4) begin
      rd(8'(a), d);
      chk_eq("R1 reset register", {32'h0, d}, 64'h0);
    end
    chk_eq("R1 reset cmd_valid", {63'h0, eng_cmd_valid}, 64'h0);
    chk_eq("R1 reset irq", {63'h0, irq}, 64'h0);

    // R2 readback
    wr(8'hC0, 32'hDEADBEEF); wr(8'hC4, 32'h01234567); wr(8'hDC, 32'h1);
    rd(8'hC0, d); chk_eq("R2 tx low readback", {32'h0, d}, 64'hDEADBEEF);
    rd(8'hC4, d); chk_eq("R2 tx high readback", {32'h0, d}, 64'h01234567);
    rd(8'hDC, d); chk_eq("R2 mask readback", {32'h0, d}, 64'h1);

    // R3 R4 R6 R9 R10: 7-bit write of three bytes
    xfer(0, 0, 10'h050, 3, 64'h0000_0000_0044_3322 << 0 | 64'h11, -1, 0, "R6 write3");
    rd(8'hD0, d); chk_eq("R3 ctrl readback", {32'h0, d}, {32'h0, ctrlw(0, 0, 10'h050, 3)});
    wait_cause();
    rd(8'hD4, d); chk_eq("R8 status clean write", {32'h0, d}, 64'h0);
    rd(8'hD8, d); chk_eq("R9 cause set", {32'h0, d}, 64'h1);
    chk_eq("R10 irq with mask", {63'h0, irq}, 64'h1);
    wr(8'hD8, 32'h0);
    rd(8'hD8, d); chk_eq("R9 cause cleared", {32'h0, d}, 64'h0);
    chk_eq("R10 irq after clear", {63'h0, irq}, 64'h0);

    // R5 R6: ten-bit write of eight bytes
    xfer(0, 1, 10'h2A5, 8, 64'h8877665544332211, -1, 0, "R5 write8 ten");
    wait_cause();
    rd(8'hD4, d); chk_eq("R5 status", {32'h0, d}, 64'h0);
    wr(8'hD8, 32'h0);

    // R7: 7-bit read of four bytes
    xfer(1, 0, 10'h03C, 4, 64'hD4C3B2A1, -1, 0, "R7 read4");
    wait_cause();
    rd(8'hC8, d); chk_eq("R7 rx low", {32'h0, d}, 64'hD4C3B2A1);
    rd(8'hCC, d); chk_eq("R7 rx high", {32'h0, d}, 64'h0);
    wr(8'hD8, 32'h0);

    // R7: eight-byte read fills both words
    xfer(1, 0, 10'h011, 8, 64'h0F1E2D3C4B5A6978, -1, 0, "R7 read8");
    wait_cause();
    rd(8'hC8, d); chk_eq("R7 rx low 8", {32'h0, d}, 64'h4B5A6978);
    rd(8'hCC, d); chk_eq("R7 rx high 8", {32'h0, d}, 64'h0F1E2D3C);
    wr(8'hD8, 32'h0);

    // R5 R7: ten-bit one-byte read
    xfer(1, 1, 10'h1C3, 1, 64'h5E, -1, 0, "R5 read1 ten");
    wait_cause();
    rd(8'hC8, d); chk_eq("R7 rx single", {32'h0, d}, 64'h5E);
    wr(8'hD8, 32'h0);

    // R8: data NACK on the second of five bytes
    xfer(0, 0, 10'h022, 5, 64'h00000055_44332211, 2, 0, "R8 data nack");
    wait_cause();
    rd(8'hD4, d); chk_eq("R8 status error data", {32'h0, d}, 64'h1);
    wr(8'hD8, 32'h0);

    // R8 R7: address NACK on a read clears rx and reports error
    xfer(1, 0, 10'h03C, 2, 64'h0, 0, 0, "R8 addr nack");
    wait_cause();
    rd(8'hD4, d); chk_eq("R8 status error addr", {32'h0, d}, 64'h1);
    rd(8'hC8, d); chk_eq("R8 rx empty low", {32'h0, d}, 64'h0);
    rd(8'hCC, d); chk_eq("R8 rx empty high", {32'h0, d}, 64'h0);

    // R10: mask off keeps irq low with cause set
    wr(8'hDC, 32'h0);
    rd(8'hD8, d); chk_eq("R10 cause still set", {32'h0, d}, 64'h1);
    chk_eq("R10 irq masked", {63'h0, irq}, 64'h0);
    wr(8'hDC, 32'h1);
    wr(8'hD8, 32'h0);

    // R12: go while busy is ignored
    lat = 12;
    xfer(0, 0, 10'h011, 4, 64'hCAFEF00D, -1, 0, "R12 busy write");
    repeat (20) @(negedge clk);
    wr(8'hD0, ctrlw(1, 0, 10'h022, 2));
    rd(8'hD0, d); chk_eq("R12 ctrl unchanged", {32'h0, d}, {32'h0, ctrlw(0, 0, 10'h011, 4)});
    wait_cause();
    chk_eq("R12 stream finished", 64'(expq.size()), 64'h0);
    wr(8'hD8, 32'h0);

    // R11: go=0 while busy abandons
    lat = 30;
    xfer(0, 0, 10'h033, 3, 64'h00ABCDEF, -1, 0, "R11 abort write");
    repeat (5) @(negedge clk);
    wr(8'hD0, 32'h0);
    chk_eq("R11 cmd_valid dropped", {63'h0, eng_cmd_valid}, 64'h0);
    rd(8'hD0, d); chk_eq("R11 ctrl cleared", {32'h0, d}, 64'h0);
    repeat (80) @(negedge clk);
    rd(8'hD8, d); chk_eq("R11 no cause", {32'h0, d}, 64'h0);
    expq.delete();
    lat = 2;

    // R9: completion and cause clear in the same cycle; set wins
    xfer(0, 0, 10'h044, 2, 64'h6655, -1, 1, "R9 collide");
    repeat (60) @(negedge clk);
    rd(8'hD8, d); chk_eq("R9 set beats clear", {32'h0, d}, 64'h1);
    chk_eq("R10 irq after collide", {63'h0, irq}, 64'h1);
    chk_eq("R4 queue drained", 64'(expq.size()), 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule